// File: doc/BRIEF.md
# Per-Instruction Partitioned Victim Selector

This block chooses which way to evict in one set of a 16-way set-associative cache. Each way records an owner: the identity of the instruction that filled it, formed from the hardware thread number and the program counter of the filling instruction. Each way also holds a position in a full least-recently-used ordering of the set. Every miss request carries the requester's owner ID and a predicted block budget, which is the number of ways that instruction is expected to need in this set.

When a miss arrives, an empty way is always used first. If the set is full, the block counts the ways the requester already owns. If it holds its whole budget, or more, it must replace one of its own blocks, and the oldest of them is taken. If it holds less than its budget, the oldest block in the whole set is taken. A requester with a budget of zero is a streaming instruction. Its fills go to the least-recently-used end of the order, so they are the next blocks evicted.

Hits only refresh recency. A miss is answered one cycle later with the victim way on a valid/ready handshake. In that same edge the way takes the new owner and its new recency position.

Top module: `svp_victim_sel`

## Requirements
- R1: After reset, `vic_valid` is low, `req_ready` is high and every way is empty.
- R2: On a miss, if any way is empty, the victim is the empty way with the lowest index, whatever the owner and budget.
- R3: An accepted miss (`req_valid && req_ready && !req_hit`) raises `vic_valid` on the next clock edge. `vic_valid` and `vic_way` then hold until a cycle with `vic_ready` high. While `vic_valid` is high, `req_ready` is low.
- R4: With the set full, the requester owning at least one way and owning at least `req_pred` ways, the victim is the least-recently-used way among the ways the requester owns.
- R5: With the set full and the requester owning fewer ways than `req_pred`, or none, the victim is the least-recently-used way of the whole set.
- R6: A miss with `req_pred` equal to 0 places the filled way at the least-recently-used position. Every other fill becomes most-recently-used.
- R7: An accepted hit (`req_hit` high) makes way `req_hit_way` most-recently-used and leaves its owner unchanged. A hit produces no victim response.
- R8: A fill marks the victim way valid and stores `req_owner` as its owner. The recency positions of the ways always form a permutation of 0 (most recent) to 15 (least recent).
- R9: Ownership compares all `ID_W` bits of the owner ID. Two IDs that differ only in the thread bit (bit 11) are different owners.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can accept a request |
| req_hit | input | 1 | 1 = hit refresh, 0 = miss needing a victim |
| req_hit_way | input | 4 | Way that hit (used when `req_hit` is 1) |
| req_owner | input | 12 | Owner ID: bit 11 thread, bits 10:0 PC bits |
| req_pred | input | 5 | Predicted block budget, 0 to 16 |
| vic_valid | output | 1 | Victim way is available |
| vic_ready | input | 1 | Consumer takes the victim way |
| vic_way | output | 4 | Chosen victim way |

## Verification
The bench targets the edges between the selection paths. These are a requester holding exactly its budget, which must evict its own block, and one holding one block fewer, which must evict the global oldest. A design using `>` in place of `>=` would pick the wrong way in one of those cases. A zero-budget requester that owns nothing must fall back to the global oldest. Its fill must then be the very next global victim, and a design that made it most-recently-used would evict a different way. The bench also uses two owners that differ only in the thread bit, so a design comparing only PC bits would see shared ownership and leave the global path. Random hits interleaved with misses expose any recency update that moves the wrong ways or touches the owner on a hit.

// File: rtl/svp_pkg.sv
package svp_pkg;

  // Which selection path produced the victim
  typedef enum logic [1:0] {
    SRC_FREE   = 2'd0,
    SRC_OWN    = 2'd1,
    SRC_GLOBAL = 2'd2
  } pick_src_e;

endpackage

// File: rtl/svp_owner_match.sv
// Flags ways held by the requesting owner and counts them.
module svp_owner_match #(
  parameter int WAYS  = 16,
  parameter int ID_W  = 12,
  parameter int CNT_W = $clog2(WAYS + 1)
) (
  input  logic [WAYS-1:0]           valid,
  input  logic [WAYS-1:0][ID_W-1:0] owner,
  input  logic [ID_W-1:0]           req_owner,
  output logic [WAYS-1:0]           match,
  output logic [CNT_W-1:0]          count
);

  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_cmp
      assign match[g] = valid[g] && (owner[g] == req_owner);
    end
  endgenerate

  always_comb begin
    count = '0;
    for (int w = 0; w < WAYS; w++) begin
      count = count + CNT_W'(match[w]);
    end
  end

endmodule

// File: rtl/svp_oldest_pick.sv
// Returns the way with the largest recency rank among the masked ways.
module svp_oldest_pick #(
  parameter int WAYS  = 16,
  parameter int AGE_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            mask,
  input  logic [WAYS-1:0][AGE_W-1:0] ages,
  output logic                       found,
  output logic [AGE_W-1:0]           way
);

  logic [AGE_W-1:0] best;

  always_comb begin
    found = 1'b0;
    way   = '0;
    best  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (mask[w] && (!found || (ages[w] > best))) begin
        found = 1'b1;
        way   = AGE_W'(w);
        best  = ages[w];
      end
    end
  end

endmodule

// File: rtl/svp_age_update.sv
// Moves one way to the MRU (rank 0) or LRU (rank WAYS-1) end of the order.
module svp_age_update #(
  parameter int WAYS  = 16,
  parameter int AGE_W = $clog2(WAYS)
) (
  input  logic                       en,
  input  logic [AGE_W-1:0]           way,
  input  logic                       to_lru,
  input  logic [WAYS-1:0][AGE_W-1:0] ages,
  output logic [WAYS-1:0][AGE_W-1:0] ages_next
);

  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

  logic [AGE_W-1:0] pivot;
  assign pivot = ages[way];

  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_rank
      always_comb begin
        ages_next[g] = ages[g];
        if (en) begin
          if (AGE_W'(g) == way) begin
            ages_next[g] = to_lru ? OLDEST : '0;
          end else if (to_lru) begin
            if (ages[g] > pivot) ages_next[g] = ages[g] - 1'b1;
          end else begin
            if (ages[g] < pivot) ages_next[g] = ages[g] + 1'b1;
          end
        end
      end
    end
  endgenerate

endmodule

// File: rtl/svp_victim_sel.sv
module svp_victim_sel #(
  parameter int WAYS = 16,
  parameter int ID_W = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_hit,
  input  logic [$clog2(WAYS)-1:0]       req_hit_way,
  input  logic [ID_W-1:0]               req_owner,
  input  logic [$clog2(WAYS+1)-1:0]     req_pred,
  output logic                          vic_valid,
  input  logic                          vic_ready,
  output logic [$clog2(WAYS)-1:0]       vic_way
);
  import svp_pkg::*;

  localparam int AGE_W = $clog2(WAYS);
  localparam int CNT_W = $clog2(WAYS + 1);

  // State
  logic [WAYS-1:0]            valid_q, valid_d;
  logic [WAYS-1:0][ID_W-1:0]  owner_q;
  logic [WAYS-1:0][AGE_W-1:0] age_q, age_d;
  logic                       vic_valid_q, vic_valid_d;
  logic [AGE_W-1:0]           vic_way_q, vic_way_d;

  // Request decode
  logic accept, miss_acc, hit_acc;
  assign req_ready = !vic_valid_q;
  assign accept    = req_valid && req_ready;
  assign miss_acc  = accept && !req_hit;
  assign hit_acc   = accept && req_hit;

  // Empty way search, lowest index wins
  logic             free_any;
  logic [AGE_W-1:0] free_way;
  assign free_any = ~&valid_q;
  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_q[w]) free_way = AGE_W'(w);
    end
  end

  // Occupancy of the requester
  logic [WAYS-1:0]  own_mask;
  logic [CNT_W-1:0] own_cnt;
  svp_owner_match #(.WAYS(WAYS), .ID_W(ID_W), .CNT_W(CNT_W)) u_match (
    .valid     (valid_q),
    .owner     (owner_q),
    .req_owner (req_owner),
    .match     (own_mask),
    .count     (own_cnt)
  );

  // Oldest among the requester's ways and oldest overall
  logic             own_found, glb_found;
  logic [AGE_W-1:0] own_way, glb_way;
  svp_oldest_pick #(.WAYS(WAYS), .AGE_W(AGE_W)) u_pick_own (
    .mask  (own_mask),
    .ages  (age_q),
    .found (own_found),
    .way   (own_way)
  );
  svp_oldest_pick #(.WAYS(WAYS), .AGE_W(AGE_W)) u_pick_glb (
    .mask  ({WAYS{1'b1}}),
    .ages  (age_q),
    .found (glb_found),
    .way   (glb_way)
  );

  // Path selection
  pick_src_e        src;
  logic             at_budget;
  logic [AGE_W-1:0] victim;
  assign at_budget = (own_cnt >= req_pred) && own_found;
  always_comb begin
    if (free_any)       src = SRC_FREE;
    else if (at_budget) src = SRC_OWN;
    else                src = SRC_GLOBAL;
    case (src)
      SRC_FREE: victim = free_way;
      SRC_OWN:  victim = own_way;
      default:  victim = glb_found ? glb_way : '0;
    endcase
  end

  // Recency update for hits and fills
  logic             upd_en, upd_lru;
  logic [AGE_W-1:0] upd_way;
  assign upd_en  = accept;
  assign upd_way = hit_acc ? req_hit_way : victim;
  assign upd_lru = miss_acc && (req_pred == '0);
  svp_age_update #(.WAYS(WAYS), .AGE_W(AGE_W)) u_age (
    .en        (upd_en),
    .way       (upd_way),
    .to_lru    (upd_lru),
    .ages      (age_q),
    .ages_next (age_d)
  );

  // Next-state logic
  always_comb begin
    valid_d     = valid_q;
    vic_valid_d = vic_valid_q;
    vic_way_d   = vic_way_q;
    if (miss_acc) begin
      valid_d[victim] = 1'b1;
      vic_valid_d     = 1'b1;
      vic_way_d       = victim;
    end else if (vic_valid_q && vic_ready) begin
      vic_valid_d = 1'b0;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q     <= '0;
      vic_valid_q <= 1'b0;
      vic_way_q   <= '0;
      for (int w = 0; w < WAYS; w++) begin
        age_q[w] <= AGE_W'(w);
      end
    end else begin
      valid_q     <= valid_d;
      vic_valid_q <= vic_valid_d;
      if (miss_acc) vic_way_q <= vic_way_d;
      if (upd_en)   age_q     <= age_d;
    end
  end

  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_owner
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          owner_q[g] <= '0;
        end else if (miss_acc && (victim == AGE_W'(g))) begin
          owner_q[g] <= req_owner;
        end
      end
    end
  endgenerate

  assign vic_valid = vic_valid_q;
  assign vic_way   = vic_way_q;

endmodule

// File: rtl/svp_victim_sel_chk.sv
module svp_victim_sel_chk #(
  parameter int WAYS = 16,
  parameter int ID_W = 12
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            req_valid,
  input logic                            req_ready,
  input logic                            req_hit,
  input logic [$clog2(WAYS)-1:0]         req_hit_way,
  input logic [ID_W-1:0]                 req_owner,
  input logic [$clog2(WAYS+1)-1:0]       req_pred,
  input logic                            vic_valid,
  input logic                            vic_ready,
  input logic [$clog2(WAYS)-1:0]         vic_way,
  input logic [WAYS-1:0]                 valid_q,
  input logic [WAYS-1:0][ID_W-1:0]       owner_q,
  input logic [WAYS-1:0][$clog2(WAYS)-1:0] age_q
);
  localparam int AGE_W = $clog2(WAYS);

  logic miss_acc, hit_acc;
  assign miss_acc = req_valid && req_ready && !req_hit;
  assign hit_acc  = req_valid && req_ready && req_hit;

  logic [WAYS-1:0] valid_prev_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_prev_q <= '0;
    else        valid_prev_q <= valid_q;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!vic_valid && valid_q == '0)) else $error("R1");  // R1

  AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_acc && !(&valid_q)) |=> !valid_prev_q[vic_way]);              // R2

  AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    miss_acc |=> vic_valid);                                             // R3

  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid && !vic_ready) |=> (vic_valid && $stable(vic_way)));      // R3

  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid |-> !req_ready);                                           // R3

  AST_STREAM_LRU: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_acc && req_pred == '0) |=> (age_q[vic_way] == AGE_W'(WAYS - 1))); // R6

  AST_FILL_MRU: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_acc && req_pred != '0) |=> (age_q[vic_way] == '0));            // R6

  AST_HIT_MRU: assert property (@(posedge clk) disable iff (!rst_n)
    hit_acc |=> (age_q[$past(req_hit_way)] == '0));                      // R7

  AST_HIT_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    hit_acc |=> (owner_q[$past(req_hit_way)] == $past(owner_q[req_hit_way]))); // R7

  AST_FILL_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    miss_acc |=> (valid_q[vic_way] && owner_q[vic_way] == $past(req_owner))); // R8

  genvar k;
  generate
    for (k = 0; k < WAYS; k++) begin : g_perm
      logic [WAYS-1:0] has_rank;
      for (genvar w = 0; w < WAYS; w++) begin : g_w
        assign has_rank[w] = (age_q[w] == AGE_W'(k));
      end
      AST_RANK_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(has_rank) == 1);                                      // R8
    end
  endgenerate

endmodule

bind svp_victim_sel svp_victim_sel_chk #(.WAYS(WAYS), .ID_W(ID_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_hit     (req_hit),
  .req_hit_way (req_hit_way),
  .req_owner   (req_owner),
  .req_pred    (req_pred),
  .vic_valid   (vic_valid),
  .vic_ready   (vic_ready),
  .vic_way     (vic_way),
  .valid_q     (valid_q),
  .owner_q     (owner_q),
  .age_q       (age_q)
);

// File: tb/tb_svp_victim_sel.sv
`timescale 1ns/1ps
module tb_svp_victim_sel;
  localparam int WAYS = 16;
  localparam int ID_W = 12;

  logic            clk;
  logic            rst_n;
  logic            req_valid;
  logic            req_ready;
  logic            req_hit;
  logic [3:0]      req_hit_way;
  logic [ID_W-1:0] req_owner;
  logic [4:0]      req_pred;
  logic            vic_valid;
  logic            vic_ready;
  logic [3:0]      vic_way;

  svp_victim_sel #(.WAYS(WAYS), .ID_W(ID_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_hit(req_hit), .req_hit_way(req_hit_way), .req_owner(req_owner),
    .req_pred(req_pred), .vic_valid(vic_valid), .vic_ready(vic_ready),
    .vic_way(vic_way)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int n_checks = 0;
  int n_fail   = 0;

  // Reference model
  bit              m_valid [WAYS];
  logic [ID_W-1:0] m_owner [WAYS];
  int              m_age   [WAYS];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int w = 0; w < WAYS; w++) begin
      m_valid[w] = 1'b0; m_owner[w] = '0; m_age[w] = w;
    end
  endtask

  task automatic model_move(input int way, input bit to_lru);
    int p;
    p = m_age[way];
    for (int w = 0; w < WAYS; w++) begin
      if (w != way) begin
        if (to_lru && m_age[w] > p) m_age[w] = m_age[w] - 1;
        if (!to_lru && m_age[w] < p) m_age[w] = m_age[w] + 1;
      end
    end
    m_age[way] = to_lru ? WAYS - 1 : 0;
  endtask

  // Expected victim and the requirement that governs it
  task automatic model_victim(input logic [ID_W-1:0] o, input int pred,
                              output int vic, output string tag);
    int cnt, best;
    vic = -1;
    for (int w = WAYS - 1; w >= 0; w--) if (!m_valid[w]) vic = w;
    if (vic >= 0) begin tag = "R2"; return; end
    cnt = 0;
    for (int w = 0; w < WAYS; w++) if (m_owner[w] == o) cnt++;
    best = -1;
    if (cnt > 0 && cnt >= pred) begin
      for (int w = 0; w < WAYS; w++)
        if (m_owner[w] == o && (best < 0 || m_age[w] > m_age[best])) best = w;
      tag = (pred == 0) ? "R6" : "R4";
    end else begin
      for (int w = 0; w < WAYS; w++)
        if (best < 0 || m_age[w] > m_age[best]) best = w;
      tag = (pred == 0) ? "R6" : "R5";
    end
    vic = best;
  endtask

  task automatic do_miss(input logic [ID_W-1:0] o, input int pred,
                         input int hold, input string force_tag);
    int exp_v; string tag; int first;
    model_victim(o, pred, exp_v, tag);
    if (force_tag != "") tag = force_tag;
    @(negedge clk);
    req_valid = 1'b1; req_hit = 1'b0; req_owner = o; req_pred = 5'(pred);
    @(negedge clk);
    req_valid = 1'b0;
    check(vic_valid == 1'b1, "R3", int'(vic_valid), 1);
    check(req_ready == 1'b0, "R3", int'(req_ready), 0);
    check(int'(vic_way) == exp_v, tag, int'(vic_way), exp_v);
    first = int'(vic_way);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(vic_valid == 1'b1 && int'(vic_way) == first, "R3", int'(vic_way), first);
    end
    m_valid[exp_v] = 1'b1; m_owner[exp_v] = o;
    model_move(exp_v, pred == 0);
    vic_ready = 1'b1;
    @(negedge clk);
    vic_ready = 1'b0;
    check(vic_valid == 1'b0 && req_ready == 1'b1, "R3", int'(vic_valid), 0);
  endtask

  task automatic do_hit(input int way);
    @(negedge clk);
    req_valid = 1'b1; req_hit = 1'b1; req_hit_way = 4'(way);
    @(negedge clk);
    req_valid = 1'b0; req_hit = 1'b0;
    check(vic_valid == 1'b0, "R7", int'(vic_valid), 0);
    model_move(way, 1'b0);
  endtask

  logic [ID_W-1:0] pool [6];

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int seed, r, w;
    seed = $urandom(32'h5eed1234);
    pool[0] = 12'h040; pool[1] = 12'h840; pool[2] = 12'h123;
    pool[3] = 12'h7f0; pool[4] = 12'h041; pool[5] = 12'hfff;
    req_valid = 1'b0; req_hit = 1'b0; req_hit_way = '0;
    req_owner = '0; req_pred = '0; vic_ready = 1'b0;
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    check(vic_valid == 1'b0, "R1", int'(vic_valid), 0);
    check(req_ready == 1'b1, "R1", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(vic_valid == 1'b0 && req_ready == 1'b1, "R1", int'(vic_valid), 0);

    // R2 and R8: fill the empty set in index order, with a long hold on one
    for (int i = 0; i < WAYS; i++) do_miss(12'h040, 16, (i == 3) ? 3 : 0, "R2");

    // R9: thread bit alone separates owners
    do_miss(12'h840, 16, 0, "R9");   // owns none -> global oldest
    do_miss(12'h840, 1, 0, "R9");    // owns one, budget one -> its own block

    // R4 / R5 boundary: owner 0x123 takes two blocks, then budget 2 vs 3
    do_miss(12'h123, 16, 0, "R5");
    do_miss(12'h123, 16, 0, "R5");
    do_miss(12'h123, 2, 0, "R4");
    do_miss(12'h123, 3, 1, "R5");

    // R6: streaming fill by a new owner becomes the next global victim
    do_miss(12'h7f0, 0, 0, "R6");
    do_miss(12'hfff, 16, 0, "R6");

    // R7: hit on the oldest way protects it from the next global pick
    for (int i = 0; i < WAYS; i++) if (m_age[i] == WAYS - 1) w = i;
    do_hit(w);
    do_miss(12'h041, 16, 0, "R7");

    // Constrained random mix
    for (int i = 0; i < 600; i++) begin
      r = int'($urandom_range(0, 9));
      if (r < 4) begin
        do_hit(int'($urandom_range(0, WAYS - 1)));
      end else begin
        int pr;
        pr = (r == 9) ? 16 : int'($urandom_range(0, 5));
        do_miss(pool[$urandom_range(0, 5)], pr, (r == 8) ? 1 : 0, "");
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule